// File: doc/BRIEF.md
# Video Timing Counter Chain

This block produces the horizontal and vertical timing of a CRT-style display controller. It keeps four counters: a character column within the scanline, a raster line within the character row, a character row within the frame, and a raster count for the vertical adjustment tail. It also keeps a "final line" verdict and an adjustment-mode flag. Every count moves only on a character-clock enable. Display enable and both syncs are derived from these counters.

Timing values come in through a narrow write port and may be changed at any time. Vertical decisions are made in fixed windows of each scanline. The final-line verdict is taken while the column is 0 or 1 and is then locked. The adjustment decision follows at column 2. Row and raster counters take their new values when the next scanline begins. The block reproduces these windows so that mid-frame rewrites behave the same way in every frame. This includes the freeze that a zero horizontal total causes.

Top module: `vid_timing_chain`

## Requirements
- R1: The column counter advances on each cycle with `chEn` high and goes to 0 on the tick where it equals the horizontal total. No counter changes on a cycle with `chEn` low.
- R2: At a scanline end outside adjustment and without a final-line verdict, the raster counter goes to 0 if it equals the raster maximum, and otherwise increments.
- R3: The row counter increments when the raster counter wraps. It can climb past the vertical total and wraps from 127 to 0.
- R4: The final-line verdict is (raster == raster maximum and row == vertical total), sampled on the ticks at column 0 and 1 only. A vertical-total write that lands at column 3 or later leaves that scanline's verdict unchanged. A frame without adjustment lasts (vertical total + 1) x (raster maximum + 1) scanlines.
- R5: If the verdict holds and the vertical adjust is above 0 at column 2, adjustment starts after that scanline. It lasts vertical-adjust scanlines, during which the adjust counter runs from 0 to vertical adjust − 1.
- R6: On entry to adjustment the row counter increments exactly once and then holds. When adjustment ends, or on a verdict without adjustment, the row and raster counters return to 0.
- R7: While the horizontal total is 0, the raster, row and adjust counters and the adjustment flag hold their values, including in the middle of adjustment.
- R8: Vertical sync starts on a column-0 or column-1 tick where the row equals the sync row, once per match. It then stays high until VS_LINES scanline ends have passed: 15 ticks for a total of 7 and VS_LINES=2.
- R9: A match is not honoured when the previous scanline ran with a horizontal total below 2.
- R10: `dispEn` is high when column < displayed columns, row < displayed rows, and adjustment is not active.
- R11: `hSync` is high when the column lies in [sync position, sync position + HS_WIDTH).
- R12: Write addresses on `wrAddr` are 0 horizontal total, 1 displayed columns, 2 horizontal sync position, 3 vertical total, 4 vertical adjust, 5 displayed rows, 6 vertical sync row, 7 raster maximum; narrower fields take the low bits of `wrData`. After reset all counters and flags are 0, every register is 0 except the two sync positions, which are all ones, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chEn | input | 1 | Character-clock enable |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register select |
| wrData | input | 8 | Register write value |
| colCnt | output | 8 | Character column |
| rasCnt | output | 5 | Raster within row |
| rowCnt | output | 7 | Character row |
| adjCnt | output | 5 | Adjustment raster count |
| inAdjust | output | 1 | Adjustment mode active |
| dispEn | output | 1 | Display enable |
| hSync | output | 1 | Horizontal sync |
| vSync | output | 1 | Vertical sync |

## Verification
Frame length is swept over every combination of three raster maxima, three vertical totals and three adjust values. This separates the product term from the adjust tail, and it shows whether the row bump in adjustment happens once or once per line. The same vertical-total write is made at column 0 and at column 3 of the final line, which tells a locked verdict apart from a live comparison. Other runs cover a zero total mid-row and mid-adjustment, a row pushed past its total up to the 127 wrap, and a divided enable. Sync and enable are compared against the observed counters over a full frame, and vertical sync is checked once with long scanlines and once with short ones.

// File: rtl/vtc_pkg.sv
package vtc_pkg;
  localparam int COL_W = 8;
  localparam int RAS_W = 5;
  localparam int ROW_W = 7;
  localparam int ADR_W = 3;
  localparam int DAT_W = 8;

  typedef enum logic [ADR_W-1:0] {
    A_HTOTAL = 3'd0,
    A_HDISP  = 3'd1,
    A_HSPOS  = 3'd2,
    A_VTOTAL = 3'd3,
    A_VADJ   = 3'd4,
    A_VDISP  = 3'd5,
    A_VSPOS  = 3'd6,
    A_RASMAX = 3'd7
  } vtc_addr_e;

  typedef struct packed {
    logic [COL_W-1:0] hTotal;
    logic [COL_W-1:0] hDisp;
    logic [COL_W-1:0] hSyncPos;
    logic [ROW_W-1:0] vTotal;
    logic [ROW_W-1:0] vDisp;
    logic [ROW_W-1:0] vSyncPos;
    logic [RAS_W-1:0] vAdj;
    logic [RAS_W-1:0] rasMax;
  } vtc_cfg_t;

  typedef struct packed {
    logic colClr;
    logic colInc;
    logic rasClr;
    logic rasInc;
    logic rowClr;
    logic rowInc;
    logic adjClr;
    logic adjInc;
    logic adjEnter;
    logic adjExit;
    logic vsStart;
    logic vsDec;
  } vtc_strobe_t;
endpackage

// File: rtl/vtc_regs.sv
module vtc_regs
  import vtc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [ADR_W-1:0] wrAddr,
  input  logic [DAT_W-1:0] wrData,
  output vtc_cfg_t         cfg
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg          <= '0;
      cfg.hSyncPos <= '1;
      cfg.vSyncPos <= '1;
    end else if (wrEn) begin
      case (vtc_addr_e'(wrAddr))
        A_HTOTAL: cfg.hTotal   <= wrData[COL_W-1:0];
        A_HDISP:  cfg.hDisp    <= wrData[COL_W-1:0];
        A_HSPOS:  cfg.hSyncPos <= wrData[COL_W-1:0];
        A_VTOTAL: cfg.vTotal   <= wrData[ROW_W-1:0];
        A_VADJ:   cfg.vAdj     <= wrData[RAS_W-1:0];
        A_VDISP:  cfg.vDisp    <= wrData[ROW_W-1:0];
        A_VSPOS:  cfg.vSyncPos <= wrData[ROW_W-1:0];
        A_RASMAX: cfg.rasMax   <= wrData[RAS_W-1:0];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/vtc_ctrl.sv
module vtc_ctrl
  import vtc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             chEn,
  input  logic [COL_W-1:0] hTotal,
  input  logic [ROW_W-1:0] vTotal,
  input  logic [ROW_W-1:0] vSyncPos,
  input  logic [RAS_W-1:0] vAdj,
  input  logic [RAS_W-1:0] rasMax,
  input  logic [COL_W-1:0] colCnt,
  input  logic [RAS_W-1:0] rasCnt,
  input  logic [ROW_W-1:0] rowCnt,
  input  logic [RAS_W-1:0] adjCnt,
  input  logic             inAdjust,
  input  logic             vsBusy,
  output vtc_strobe_t      stb
);
  localparam logic [COL_W-1:0] EARLY_END  = COL_W'(2);
  localparam logic [COL_W-1:0] DECIDE_COL = COL_W'(2);

  logic armLast;
  logic adjDec;
  logic lineShort;
  logic matchSeen;

  logic earlyCol, lineEnd, vStep, armNow, enterNow, rowMatch, adjDone, shortTotal;

  always_comb begin
    shortTotal = hTotal < EARLY_END;
    earlyCol   = colCnt < EARLY_END;
    lineEnd    = chEn && (colCnt == hTotal);
    vStep      = lineEnd && (hTotal != '0);
    armNow     = (rasCnt == rasMax) && (rowCnt == vTotal);
    enterNow   = shortTotal ? (vAdj != '0) : adjDec;
    rowMatch   = rowCnt == vSyncPos;
    adjDone    = RAS_W'(adjCnt + 1'b1) == vAdj;
  end

  always_comb begin
    stb        = '0;
    stb.colClr = lineEnd;
    stb.colInc = chEn && !lineEnd;
    if (vStep) begin
      if (inAdjust) begin
        if (adjDone) begin
          stb.adjExit = 1'b1;
          stb.adjClr  = 1'b1;
          stb.rowClr  = 1'b1;
          stb.rasClr  = 1'b1;
        end else begin
          stb.adjInc = 1'b1;
        end
      end else if (armLast) begin
        stb.rasClr = 1'b1;
        if (enterNow) begin
          stb.adjEnter = 1'b1;
          stb.adjClr   = 1'b1;
          stb.rowInc   = 1'b1;
        end else begin
          stb.rowClr = 1'b1;
        end
      end else if (rasCnt == rasMax) begin
        stb.rasClr = 1'b1;
        stb.rowInc = 1'b1;
      end else begin
        stb.rasInc = 1'b1;
      end
    end
    stb.vsStart = chEn && earlyCol && rowMatch && !matchSeen && !lineShort;
    stb.vsDec   = vStep && vsBusy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armLast   <= 1'b0;
      adjDec    <= 1'b0;
      lineShort <= 1'b0;
      matchSeen <= 1'b0;
    end else begin
      if (chEn && earlyCol) begin
        armLast   <= armNow;
        matchSeen <= rowMatch;
      end
      if (chEn && colCnt == DECIDE_COL) begin
        adjDec <= armLast && (vAdj != '0);
      end
      if (lineEnd) begin
        lineShort <= shortTotal;
      end
    end
  end
endmodule

// File: rtl/vtc_dpath.sv
module vtc_dpath
  import vtc_pkg::*;
#(
  parameter int HS_WIDTH = 3,
  parameter int VS_LINES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  vtc_strobe_t      stb,
  input  logic [COL_W-1:0] hDisp,
  input  logic [COL_W-1:0] hSyncPos,
  input  logic [ROW_W-1:0] vDisp,
  output logic [COL_W-1:0] colCnt,
  output logic [RAS_W-1:0] rasCnt,
  output logic [ROW_W-1:0] rowCnt,
  output logic [RAS_W-1:0] adjCnt,
  output logic             inAdjust,
  output logic             vsBusy,
  output logic             dispEn,
  output logic             hSync,
  output logic             vSync
);
  localparam int VS_CW = $clog2(VS_LINES + 1);
  localparam logic [VS_CW-1:0] VS_LOAD = VS_CW'(VS_LINES);
  localparam logic [COL_W-1:0] HS_SPAN = COL_W'(HS_WIDTH);

  logic [VS_CW-1:0] vsLeft;
  logic [COL_W-1:0] hsOffset;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colCnt   <= '0;
      rasCnt   <= '0;
      rowCnt   <= '0;
      adjCnt   <= '0;
      inAdjust <= 1'b0;
      vsLeft   <= '0;
    end else begin
      if (stb.colClr)      colCnt <= '0;
      else if (stb.colInc) colCnt <= colCnt + 1'b1;

      if (stb.rasClr)      rasCnt <= '0;
      else if (stb.rasInc) rasCnt <= rasCnt + 1'b1;

      if (stb.rowClr)      rowCnt <= '0;
      else if (stb.rowInc) rowCnt <= rowCnt + 1'b1;

      if (stb.adjClr)      adjCnt <= '0;
      else if (stb.adjInc) adjCnt <= adjCnt + 1'b1;

      if (stb.adjEnter)     inAdjust <= 1'b1;
      else if (stb.adjExit) inAdjust <= 1'b0;

      if (stb.vsStart)    vsLeft <= VS_LOAD;
      else if (stb.vsDec) vsLeft <= vsLeft - 1'b1;
    end
  end

  always_comb begin
    hsOffset = colCnt - hSyncPos;
    vsBusy   = vsLeft != '0;
    vSync    = vsBusy;
    hSync    = (colCnt >= hSyncPos) && (hsOffset < HS_SPAN);
    dispEn   = (colCnt < hDisp) && (rowCnt < vDisp) && !inAdjust;
  end
endmodule

// File: rtl/vid_timing_chain.sv
module vid_timing_chain
  import vtc_pkg::*;
#(
  parameter int HS_WIDTH = 3,
  parameter int VS_LINES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chEn,
  input  logic             wrEn,
  input  logic [ADR_W-1:0] wrAddr,
  input  logic [DAT_W-1:0] wrData,
  output logic [COL_W-1:0] colCnt,
  output logic [RAS_W-1:0] rasCnt,
  output logic [ROW_W-1:0] rowCnt,
  output logic [RAS_W-1:0] adjCnt,
  output logic             inAdjust,
  output logic             dispEn,
  output logic             hSync,
  output logic             vSync
);
  vtc_cfg_t    cfg;
  vtc_strobe_t stb;
  logic        vsBusy;

  vtc_regs u_regs (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .cfg    (cfg)
  );

  vtc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .chEn     (chEn),
    .hTotal   (cfg.hTotal),
    .vTotal   (cfg.vTotal),
    .vSyncPos (cfg.vSyncPos),
    .vAdj     (cfg.vAdj),
    .rasMax   (cfg.rasMax),
    .colCnt   (colCnt),
    .rasCnt   (rasCnt),
    .rowCnt   (rowCnt),
    .adjCnt   (adjCnt),
    .inAdjust (inAdjust),
    .vsBusy   (vsBusy),
    .stb      (stb)
  );

  vtc_dpath #(
    .HS_WIDTH (HS_WIDTH),
    .VS_LINES (VS_LINES)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .hDisp    (cfg.hDisp),
    .hSyncPos (cfg.hSyncPos),
    .vDisp    (cfg.vDisp),
    .colCnt   (colCnt),
    .rasCnt   (rasCnt),
    .rowCnt   (rowCnt),
    .adjCnt   (adjCnt),
    .inAdjust (inAdjust),
    .vsBusy   (vsBusy),
    .dispEn   (dispEn),
    .hSync    (hSync),
    .vSync    (vSync)
  );
endmodule

// File: rtl/vid_timing_chain_chk.sv
module vid_timing_chain_chk
  import vtc_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             chEn,
  input logic [COL_W-1:0] colCnt,
  input logic [RAS_W-1:0] rasCnt,
  input logic [ROW_W-1:0] rowCnt,
  input logic [RAS_W-1:0] adjCnt,
  input logic             inAdjust,
  input logic             dispEn,
  input logic             vSync,
  input logic [COL_W-1:0] hTotal,
  input logic [ROW_W-1:0] vSyncPos
);
  p_col_wrap_r1: assert property (@(posedge clk) disable iff (!rstN)
    chEn && colCnt == hTotal |=> colCnt == '0);

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !chEn |=> $stable(colCnt) && $stable(rasCnt) && $stable(rowCnt) && $stable(adjCnt));

  p_row_bump_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inAdjust) |-> rowCnt == ROW_W'($past(rowCnt) + 1'b1));

  p_row_still_r6: assert property (@(posedge clk) disable iff (!rstN)
    inAdjust && $past(inAdjust) |-> $stable(rowCnt));

  p_frame_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(inAdjust) |-> rowCnt == '0 && rasCnt == '0);

  p_freeze_r7: assert property (@(posedge clk) disable iff (!rstN)
    chEn && hTotal == '0 |=> $stable(rasCnt) && $stable(rowCnt) && $stable(adjCnt) && $stable(inAdjust));

  p_vs_row_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vSync) |-> $past(rowCnt) == $past(vSyncPos));

  p_blank_adj_r10: assert property (@(posedge clk) disable iff (!rstN)
    inAdjust |-> !dispEn);
endmodule

bind vid_timing_chain vid_timing_chain_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .chEn     (chEn),
  .colCnt   (colCnt),
  .rasCnt   (rasCnt),
  .rowCnt   (rowCnt),
  .adjCnt   (adjCnt),
  .inAdjust (inAdjust),
  .dispEn   (dispEn),
  .vSync    (vSync),
  .hTotal   (cfg.hTotal),
  .vSyncPos (cfg.vSyncPos)
);

// File: tb/vid_timing_chain_tb.sv
module vid_timing_chain_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       chEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] colCnt;
  logic [4:0] rasCnt;
  logic [6:0] rowCnt;
  logic [4:0] adjCnt;
  logic       inAdjust, dispEn, hSync, vSync;

  int  nTests = 0;
  int  nFail = 0;
  int  ticks = 0;
  int  cycles = 0;
  bit  divMode = 0;
  bit  prevStart = 0;
  bit  startEdge = 0;
  bit  prevVs = 0;
  bit  vsRiseNow = 0;

  int fAdjMax, fAdjRow, fRasMax, fVsRise, fVsRow, fVsCol, fVsHigh, fDispBad, fHsBad;
  int hsPosTb = 255, hDispTb = 0, vDispTb = 0;

  vid_timing_chain u_dut (
    .clk(clk), .rstN(rstN), .chEn(chEn), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .colCnt(colCnt), .rasCnt(rasCnt), .rowCnt(rowCnt), .adjCnt(adjCnt),
    .inAdjust(inAdjust), .dispEn(dispEn), .hSync(hSync), .vSync(vSync)
  );

  always #5 clk = ~clk;

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual %0d cycles, expected under 190000", cycles);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit isStart();
    return colCnt == 0 && rasCnt == 0 && rowCnt == 0 && !inAdjust;
  endfunction

  task automatic step();
    @(negedge clk);
    if (chEn) ticks++;
    startEdge = isStart() && !prevStart;
    prevStart = isStart();
    vsRiseNow = vSync && !prevVs;
    prevVs    = vSync;
    chEn      = divMode ? ~chEn : 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    wrEn = 1'b1; wrAddr = a; wrData = 8'(d);
    step();
    wrEn = 1'b0;
  endtask

  task automatic waitStart();
    int guard = 0;
    do begin
      step();
      guard++;
    end while (!startEdge && guard < 20000);
    chk(guard < 20000, "R4 frame start reached", guard, 20000);
  endtask

  // Runs from one frame start to the next, recording observations.
  task automatic runFrame();
    int guard = 0;
    ticks = 0;
    fAdjMax = -1; fAdjRow = -1; fRasMax = 0;
    fVsRise = 0; fVsRow = -1; fVsCol = -1; fVsHigh = 0; fDispBad = 0; fHsBad = 0;
    forever begin
      step();
      guard++;
      if (startEdge || guard > 20000) break;
      if (inAdjust) begin
        if (int'(adjCnt) > fAdjMax) fAdjMax = adjCnt;
        fAdjRow = rowCnt;
      end
      if (int'(rasCnt) > fRasMax) fRasMax = rasCnt;
      if (vsRiseNow) begin fVsRise++; fVsRow = rowCnt; fVsCol = colCnt; end
      if (vSync) fVsHigh++;
      if (dispEn !== (int'(colCnt) < hDispTb && int'(rowCnt) < vDispTb && !inAdjust)) fDispBad++;
      if (hSync !== (int'(colCnt) >= hsPosTb && int'(colCnt) < hsPosTb + 3)) fHsBad++;
    end
  endtask

  initial begin
    int len;
    int guard;
    bit saw127, wrapOk;
    int maxRow;

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(colCnt == 0 && rasCnt == 0 && rowCnt == 0 && adjCnt == 0, "R12 reset counters", colCnt, 0);
    chk(!inAdjust && !dispEn && !hSync && !vSync, "R12 reset outputs",
        {inAdjust, dispEn, hSync, vSync}, 0);
    // R7 total of zero out of reset: vertical counters idle
    repeat (20) step();
    chk(rasCnt == 0 && rowCnt == 0 && colCnt == 0, "R7 idle with zero total", rowCnt, 0);

    // R4/R5/R6/R2 sweep of frame length
    wr(3'd0, 7);
    for (int rm = 0; rm < 3; rm++) begin
      for (int vi = 0; vi < 3; vi++) begin
        for (int ai = 0; ai < 3; ai++) begin
          int vt, va, expLen;
          vt = (vi == 2) ? 3 : vi;
          va = (ai == 2) ? 3 : ai;
          wr(3'd7, rm);
          wr(3'd3, vt);
          wr(3'd4, va);
          waitStart();
          runFrame();
          expLen = 8 * ((vt + 1) * (rm + 1) + va);
          chk(ticks == expLen, "R4/R12 frame length", ticks, expLen);
          chk(fRasMax == rm, "R2 raster peak", fRasMax, rm);
          if (va > 0) begin
            chk(fAdjMax == va - 1, "R5 adjust count peak", fAdjMax, va - 1);
            chk(fAdjRow == vt + 1, "R6 row bumped once", fAdjRow, vt + 1);
          end else begin
            chk(fAdjMax == -1, "R5 no adjustment", fAdjMax, -1);
          end
        end
      end
    end

    // R4 late write at column 3 of the final line keeps the verdict
    wr(3'd7, 1); wr(3'd3, 3); wr(3'd4, 0);
    waitStart();
    ticks = 0;
    guard = 0;
    do begin step(); guard++; end
      while (!(rowCnt == 3 && rasCnt == 1 && colCnt == 3) && guard < 5000);
    wr(3'd3, 5);
    waitStart();
    chk(ticks == 64, "R4 late write leaves verdict", ticks, 64);
    runFrame();
    chk(ticks == 96, "R4 new total next frame", ticks, 96);
    // same write at column 0 changes the verdict
    wr(3'd3, 3);
    waitStart();
    ticks = 0;
    guard = 0;
    do begin step(); guard++; end
      while (!(rowCnt == 3 && rasCnt == 1 && colCnt == 0) && guard < 5000);
    wr(3'd3, 5);
    waitStart();
    chk(ticks == 96, "R4 early write changes verdict", ticks, 96);

    // R7 freeze in the middle of a row
    wr(3'd3, 3);
    waitStart();
    guard = 0;
    do begin step(); guard++; end
      while (!(rowCnt == 2 && rasCnt == 0 && colCnt == 4) && guard < 5000);
    wr(3'd0, 0);
    repeat (300) step();
    chk(rowCnt == 2 && rasCnt == 0, "R7 row/raster frozen", rowCnt, 2);
    chk(colCnt == 0, "R7 column parks at 0", colCnt, 0);
    wr(3'd0, 7);
    waitStart();
    runFrame();
    chk(ticks == 64, "R7 resumes after freeze", ticks, 64);

    // R7 freeze in the middle of adjustment
    wr(3'd7, 0); wr(3'd3, 1); wr(3'd4, 3);
    waitStart();
    guard = 0;
    do begin step(); guard++; end
      while (!(inAdjust && adjCnt == 1 && colCnt == 4) && guard < 5000);
    wr(3'd0, 0);
    repeat (300) step();
    chk(inAdjust && adjCnt == 1 && rowCnt == 2, "R7 stays mid-adjust", adjCnt, 1);
    wr(3'd0, 7);
    wr(3'd4, 0);

    // R3 row climbs past the total and wraps after 127
    wr(3'd7, 0); wr(3'd3, 3);
    waitStart();
    guard = 0;
    do begin step(); guard++; end while (!(rowCnt == 2 && colCnt == 4) && guard < 5000);
    wr(3'd3, 0);
    saw127 = 0; wrapOk = 0; maxRow = 0; guard = 0;
    do begin
      step();
      guard++;
      if (int'(rowCnt) > maxRow) maxRow = rowCnt;
      if (saw127 && rowCnt != 127) begin
        wrapOk = (rowCnt == 0);
        break;
      end
      if (rowCnt == 127) saw127 = 1;
    end while (guard < 5000);
    chk(maxRow == 127, "R3 row climbs past total", maxRow, 127);
    chk(wrapOk, "R3 row wraps 127 to 0", rowCnt, 0);

    // R8 vertical sync once per frame at the sync row
    wr(3'd7, 1); wr(3'd3, 3); wr(3'd6, 2);
    waitStart();
    runFrame();
    chk(fVsRise == 1, "R8 one sync per frame", fVsRise, 1);
    chk(fVsRow == 2 && fVsCol == 1, "R8 sync starts at sync row", fVsRow, 2);
    chk(fVsHigh == 15, "R8 sync length", fVsHigh, 15);

    // R9 short scanlines suppress the sync
    wr(3'd0, 1);
    waitStart();
    runFrame();
    runFrame();
    chk(ticks == 16, "R9 short-line frame length", ticks, 16);
    chk(fVsRise == 0, "R9 sync suppressed", fVsRise, 0);
    wr(3'd0, 7);

    // R10/R11 display enable and horizontal sync across a frame
    wr(3'd1, 5); wr(3'd2, 4); wr(3'd5, 2); wr(3'd4, 2); wr(3'd6, 127);
    hDispTb = 5; hsPosTb = 4; vDispTb = 2;
    waitStart();
    runFrame();
    chk(fDispBad == 0, "R10 display enable", fDispBad, 0);
    chk(fHsBad == 0, "R11 horizontal sync window", fHsBad, 0);

    // R1 divided enable keeps the same length in ticks
    wr(3'd7, 1); wr(3'd3, 1); wr(3'd4, 1);
    divMode = 1;
    waitStart();
    runFrame();
    chk(ticks == 40, "R1 divided enable frame ticks", ticks, 40);
    divMode = 0;

    finish_run();
  end
endmodule